// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block sits between a memory controller and a pseudo-SRAM. It controls the part's power states. After reset it holds chip select inactive for a long power-up interval and only then lets the access controller reach the memory. When the host asks for sleep and the access controller is idle, the block pulls the low-power pin low and keeps chip select high. This puts the part in deep power-down, where its internal refresh stops. On a wake request it releases the low-power pin. It then keeps chip select high for a long recovery interval before access is allowed again.

All three intervals are given in nanoseconds and converted to clock cycles from the clock frequency parameter, rounding up. Deep power-down discards the array contents. For that reason a sticky flag tells the host after every exit that the memory must be treated as unwritten. The flag stays set until the host acknowledges it.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset is released, `pwr_state` stays in power-up wait for exactly ceil(POWERUP_NS * CLK_FREQ_HZ / 1e9) clock cycles and then changes to active.
- R2: `access_ready` is high only in the active state. `mem_cs_n` equals `ctrl_cs_n` in the active state and is 1 in every other state.
- R3: In the active state, a `sleep_req` sampled together with `ctrl_idle`=1 moves the block to the enter-power-down state on the next cycle. With `ctrl_idle`=0 the request has no effect and the state stays active.
- R4: `mem_zz_n` is 0 exactly while the state is enter-power-down or power-down. The enter-power-down state lasts ceil(ZZ_MIN_NS * CLK_FREQ_HZ / 1e9) cycles.
- R5: A `wake_req` seen during enter-power-down is remembered. When the minimum low-pin interval ends, the block goes straight to recovery instead of power-down.
- R6: In power-down, `wake_req` moves the block to recovery on the next cycle. Recovery lasts ceil(RECOVER_NS * CLK_FREQ_HZ / 1e9) cycles, after which the state is active.
- R7: `data_lost` becomes 1 on the cycle the block enters recovery and stays 1 until `data_lost_ack` is sampled high. If a set and an acknowledge fall in the same cycle, the set wins. Reset clears the flag.
- R8: `pwr_state` codes are: 0 power-up wait, 1 active, 2 enter-power-down, 3 power-down, 4 recovery. Reset (synchronous, active high) gives state 0 with `mem_zz_n`=1, `mem_cs_n`=1, `access_ready`=0.
- R9: `sleep_req` outside the active state and `wake_req` in power-up wait, active or recovery have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Host asks for deep power-down |
| wake_req | input | 1 | Host asks to leave deep power-down |
| ctrl_idle | input | 1 | Access controller has no transfer in flight |
| ctrl_cs_n | input | 1 | Chip select from the access controller |
| data_lost_ack | input | 1 | Host clears the lost-contents flag |
| mem_cs_n | output | 1 | Gated chip select to the memory |
| mem_zz_n | output | 1 | Low-power pin to the memory, low = power-down |
| access_ready | output | 1 | Memory may be accessed |
| pwr_state | output | 3 | Current power state code |
| data_lost | output | 1 | Sticky: contents invalid after a power-down exit |

## Verification
The assertions assume that `ctrl_cs_n` and the request inputs are clean, synchronous levels. They also assume that reset is applied before the first checked edge. They make no assumption about how long requests stay high, because the block must tolerate pulses of one cycle and held levels alike. The stimulus changes inputs just after a clock edge and keeps the memory-facing outputs to what the block itself drives. It uses short nanosecond overrides, so every timed interval completes many times within the run, and it includes wake pulses that arrive inside the minimum low-pin window.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_POWERUP = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_ENTER   = 3'd2,
        PS_DPD     = 3'd3,
        PS_RECOVER = 3'd4
    } pwr_state_e;

    // Cycles needed to cover a time in ns, rounded up, at least one.
    function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_CNT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_CNT);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R1
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
    import psram_pwr_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ZZ_CYC  = 3,
    parameter int unsigned REC_CYC = 25000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic             wake_req,
    input  logic             ctrl_idle,
    input  logic             tmr_done,
    output pwr_state_e       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             exit_evt
);
    pwr_state_e state_n;
    logic       wake_pend, wake_pend_n;

    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            PS_POWERUP: if (tmr_done) state_n = PS_ACTIVE;
            PS_ACTIVE: begin
                if (sleep_req && ctrl_idle) begin
                    state_n  = PS_ENTER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(ZZ_CYC - 1);
                end
            end
            PS_ENTER: begin
                if (tmr_done) begin
                    if (wake_req || wake_pend) begin
                        state_n  = PS_RECOVER;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(REC_CYC - 1);
                    end else begin
                        state_n = PS_DPD;
                    end
                end
            end
            PS_DPD: begin
                if (wake_req) begin
                    state_n  = PS_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            PS_RECOVER: if (tmr_done) state_n = PS_ACTIVE;
            default:    state_n = PS_POWERUP;
        endcase
    end

    assign wake_pend_n = (state == PS_ENTER) && !tmr_done && (wake_pend || wake_req);
    assign exit_evt    = (state_n == PS_RECOVER) && (state != PS_RECOVER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PS_POWERUP;
            wake_pend <= 1'b0;
        end else begin
            state     <= state_n;
            wake_pend <= wake_pend_n;
        end
    end

    // R3
    sleep_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ACTIVE && sleep_req && ctrl_idle) |=> (state == PS_ENTER));

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DPD && wake_req) |=> (state == PS_RECOVER));

    // R5
    no_dpd_when_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ENTER && wake_pend) |=> (state != PS_DPD));

endmodule

// File: rtl/psram_pwr_flag.sv
module psram_pwr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (ack) flag <= 1'b0;
    end

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 125_000_000,
    parameter longint unsigned POWERUP_NS  = 200_000,
    parameter longint unsigned RECOVER_NS  = 200_000,
    parameter longint unsigned ZZ_MIN_NS   = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       ctrl_idle,
    input  logic       ctrl_cs_n,
    input  logic       data_lost_ack,
    output logic       mem_cs_n,
    output logic       mem_zz_n,
    output logic       access_ready,
    output logic [2:0] pwr_state,
    output logic       data_lost
);
    localparam int unsigned PU_CYC  = ns_to_cycles(POWERUP_NS, CLK_FREQ_HZ);
    localparam int unsigned REC_CYC = ns_to_cycles(RECOVER_NS, CLK_FREQ_HZ);
    localparam int unsigned ZZ_CYC  = ns_to_cycles(ZZ_MIN_NS, CLK_FREQ_HZ);
    localparam int unsigned CNT_W   = $clog2(max3(PU_CYC, REC_CYC, ZZ_CYC) + 1);

    pwr_state_e       state;
    logic             tmr_load, tmr_done, exit_evt;
    logic [CNT_W-1:0] tmr_val;

    psram_pwr_timer #(
        .CNT_W   (CNT_W),
        .RST_CNT (PU_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_pwr_fsm #(
        .CNT_W   (CNT_W),
        .ZZ_CYC  (ZZ_CYC),
        .REC_CYC (REC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .ctrl_idle (ctrl_idle),
        .tmr_done  (tmr_done),
        .state     (state),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .exit_evt  (exit_evt)
    );

    psram_pwr_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (exit_evt),
        .ack  (data_lost_ack),
        .flag (data_lost)
    );

    assign access_ready = (state == PS_ACTIVE);
    assign mem_cs_n     = access_ready ? ctrl_cs_n : 1'b1;
    assign mem_zz_n     = !((state == PS_ENTER) || (state == PS_DPD));
    assign pwr_state    = state;

    // R2
    cs_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !access_ready |-> mem_cs_n);

    // R4
    zz_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_zz_n |-> mem_cs_n);

    // R6
    zz_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_zz_n) |-> (pwr_state == 3'd4 && data_lost));

endmodule

// File: tb/psram_pwr_seq_test.sv
module psram_pwr_seq_test;
    localparam int PU_CYC  = 100;   // 800 ns at 125 MHz
    localparam int REC_CYC = 50;    // 400 ns
    localparam int ZZ_CYC  = 5;     // 40 ns

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b1;
    logic ctrl_cs_n = 1'b1, data_lost_ack = 1'b0;
    logic mem_cs_n, mem_zz_n, access_ready, data_lost;
    logic [2:0] pwr_state;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_st = 0, m_cnt = PU_CYC - 1;
    bit m_pend = 0, m_lost = 0;

    always #4 clk = ~clk;

    psram_pwr_seq #(
        .CLK_FREQ_HZ (125_000_000),
        .POWERUP_NS  (800),
        .RECOVER_NS  (400),
        .ZZ_MIN_NS   (40)
    ) uut (
        .clk (clk), .rst (rst), .sleep_req (sleep_req), .wake_req (wake_req),
        .ctrl_idle (ctrl_idle), .ctrl_cs_n (ctrl_cs_n), .data_lost_ack (data_lost_ack),
        .mem_cs_n (mem_cs_n), .mem_zz_n (mem_zz_n), .access_ready (access_ready),
        .pwr_state (pwr_state), .data_lost (data_lost)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: integer state with a remaining-cycle count.
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = PU_CYC - 1; m_pend = 0; m_lost = 0;
        end else begin
            bit entering;
            int nst;
            entering = 0;
            nst = m_st;
            case (m_st)
                0: if (m_cnt == 0) nst = 1; else m_cnt--;
                1: if (sleep_req && ctrl_idle) begin nst = 2; m_cnt = ZZ_CYC - 1; end
                2: begin
                    if (m_cnt == 0) begin
                        if (wake_req || m_pend) begin nst = 4; m_cnt = REC_CYC - 1; entering = 1; end
                        else nst = 3;
                        m_pend = 0;
                    end else begin
                        m_cnt--;
                        if (wake_req) m_pend = 1;
                    end
                end
                3: if (wake_req) begin nst = 4; m_cnt = REC_CYC - 1; entering = 1; end
                4: if (m_cnt == 0) nst = 1; else m_cnt--;
                default: nst = 0;
            endcase
            m_st = nst;
            if (entering) m_lost = 1;
            else if (data_lost_ack) m_lost = 0;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R8 state", int'(pwr_state), m_st);
            check("R4 zz", int'(mem_zz_n), (m_st == 2 || m_st == 3) ? 0 : 1);
            check("R2 ready", int'(access_ready), (m_st == 1) ? 1 : 0);
            check("R2 cs", int'(mem_cs_n), (m_st == 1) ? int'(ctrl_cs_n) : 1);
            check("R7 lost", int'(data_lost), int'(m_lost));
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog run hung actual=0 expected=1");
        finish_run();
    end

    initial begin
        int n;
        tick(3);
        // R8 reset values
        check("R8 reset state", int'(pwr_state), 0);
        check("R8 reset zz", int'(mem_zz_n), 1);
        check("R8 reset cs", int'(mem_cs_n), 1);
        check("R8 reset ready", int'(access_ready), 0);
        rst = 0;
        ctrl_cs_n = 0;
        // R1 power-up duration
        n = 0;
        while (!access_ready && n < 1000) begin tick(); n++; end
        check("R1 powerup cycles", n, PU_CYC);

        // R2 chip select passes in active
        ctrl_cs_n = 0; tick(2);
        check("R2 cs follows", int'(mem_cs_n), 0);
        ctrl_cs_n = 1; tick(1);

        // R3 and R9: busy controller blocks sleep, wake ignored in active
        ctrl_idle = 0; sleep_req = 1; wake_req = 1; tick(6);
        check("R3 busy sleep ignored", int'(pwr_state), 1);
        check("R9 wake in active", int'(pwr_state), 1);
        wake_req = 0; ctrl_idle = 1; tick(1);
        check("R3 sleep accepted", int'(pwr_state), 2);
        sleep_req = 0; ctrl_cs_n = 0;
        tick(ZZ_CYC - 1);
        check("R4 still entering", int'(pwr_state), 2);
        tick(1);
        check("R4 into power-down", int'(pwr_state), 3);
        check("R2 cs held high", int'(mem_cs_n), 1);
        check("R4 zz low", int'(mem_zz_n), 0);
        sleep_req = 1; tick(10); sleep_req = 0;
        check("R9 sleep in dpd", int'(pwr_state), 3);

        // R6 wake and recovery length
        wake_req = 1; tick(1); wake_req = 0;
        check("R6 recover", int'(pwr_state), 4);
        check("R7 lost set", int'(data_lost), 1);
        n = 1;
        sleep_req = 1; wake_req = 1;
        while (!access_ready && n < 1000) begin tick(); n++; end
        sleep_req = 0; wake_req = 0;
        check("R6 recover cycles", n, REC_CYC + 1);
        check("R7 lost sticky", int'(data_lost), 1);
        data_lost_ack = 1; tick(1); data_lost_ack = 0;
        check("R7 ack clears", int'(data_lost), 0);

        // R5 wake inside the minimum pulse window
        sleep_req = 1; tick(1); sleep_req = 0;
        wake_req = 1; tick(1); wake_req = 0;
        check("R5 deferred", int'(pwr_state), 2);
        tick(ZZ_CYC - 2);
        check("R5 still low", int'(mem_zz_n), 0);
        data_lost_ack = 1;
        tick(1);
        check("R5 straight to recover", int'(pwr_state), 4);
        check("R7 set beats ack", int'(data_lost), 1);
        tick(REC_CYC + 2);
        data_lost_ack = 0;
        check("R6 active again", int'(access_ready), 1);

        // Repeat with a held wake level and short controller busy gaps
        for (int k = 0; k < 4; k++) begin
            ctrl_idle = (k % 2 == 0);
            sleep_req = 1; tick(2); sleep_req = 0; ctrl_idle = 1;
            tick(k * 3);
            wake_req = 1; tick(1 + k); wake_req = 0;
            ctrl_cs_n = ~ctrl_cs_n;
            tick(REC_CYC + ZZ_CYC + 3);
            data_lost_ack = 1; tick(1); data_lost_ack = 0;
        end
        tick(5);
        finish_run();
    end
endmodule